// File: doc/BRIEF.md
# Receive Error Status Flags with Debug-Break Protection

This block keeps the two error status flags of a serial receiver: one for a missing stop bit and one for a parity mismatch. The receiver sends a one-cycle strobe for each error, and the matching flag sets and stays set. Each flag has its own enable bit in a small control register. A single error interrupt request is driven from every flag whose enable is 1.

Software clears a flag in two steps. First it reads the status register while the flag is set. Then it reads or writes the data register. A new error strobe between the two steps, or in the same cycle as the second step, keeps the flag set and drops the pending clear.

A debug-break input freezes this clearing sequence. While the break is active and the break-clear-enable input is 0, CPU accesses leave the flags and any pending clear as they were. A status read made before the break therefore still completes when the data register is accessed after the break. With break-clear-enable at 1, clears made during the break work normally and remain in effect after it.

Top module: `rx_err_status`

## Requirements
- R1: A one-cycle `frameErrStrobe` sets `frameErrFlag` (status bit 0) at the next clock edge.
- R2: A one-cycle `parityErrStrobe` sets `parityErrFlag` (status bit 1) at the next clock edge.
- R3: A write to the control address (2) loads the enables: data bit 0 enables the framing flag and data bit 1 enables the parity flag. `errIrq` is 1 exactly when some flag is set and its enable is 1.
- R4: A status read (address 0) that sees a flag set, followed later by a read or write of the data address (address 1), clears that flag at the edge of the data access.
- R5: A data access with no earlier status read that saw the flag set leaves the flag set.
- R6: An error strobe that arrives after the status read and before the data access keeps the flag set and cancels the pending clear, so the following data access also leaves the flag set.
- R7: An error strobe in the same cycle as the completing data access keeps the flag set. The pending clear is used up by that access.
- R8: While `brkActive` is 1 and `brkClrEn` is 0, status reads and data accesses change neither the flags nor the pending-clear state.
- R9: A status read made before a break, with `brkClrEn` at 0 during the break, leaves the clear pending. A data access after the break ends then clears the flag.
- R10: While `brkActive` is 1 and `brkClrEn` is 1, the two-step clear works, and the flag stays clear after the break ends.
- R11: A synchronous active-high `rst` clears both flags, both enables and the pending-clear state, so `errIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frameErrStrobe | input | 1 | Receiver saw a 0 where the stop bit belongs |
| parityErrStrobe | input | 1 | Receiver saw a parity mismatch |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cpuAddr | input | ADDR_W (2) | Register address: 0 status, 1 data, 2 control |
| cpuWdata | input | DATA_W (8) | CPU write data |
| brkActive | input | 1 | Debug break state |
| brkClrEn | input | 1 | Lets CPU accesses clear flags during a break |
| frameErrFlag | output | 1 | Framing error flag |
| parityErrFlag | output | 1 | Parity error flag |
| errIrq | output | 1 | Combined, enabled error interrupt request |

## Verification
The assertions check four rules on every cycle. A strobe always leaves its flag set, with no clear pending. A flag never falls unless a pending clear meets a data access. A pending clear never exists without its flag. A frozen break never lowers a flag. The interrupt request is also checked so that it is never raised without a set flag. Only the bench scenarios can show that the two steps must come in order, that a strobe cancels a clear, and that a clear made before a break stays pending across it. The same holds for the control-register bit mapping and the reset of the enables.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_FRAME = 0;
  localparam int FLAG_PARITY = 1;

  typedef struct packed {
    logic statRd;
    logic dataAcc;
    logic ctrlWr;
  } cpuStrb_t;
endpackage

// File: rtl/rx_err_ctrl.sv
module rx_err_ctrl
  import rx_err_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1,
  parameter int CTRL_ADDR = 2
) (
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              brkActive,
  input  logic              brkClrEn,
  output cpuStrb_t          strb
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic accessOk;

  always_comb begin
    accessOk     = !brkActive || brkClrEn;
    strb.statRd  = accessOk && cpuRd && (cpuAddr == STAT_A);
    strb.dataAcc = accessOk && (cpuRd || cpuWr) && (cpuAddr == DATA_A);
    strb.ctrlWr  = cpuWr && (cpuAddr == CTRL_A);
  end
endmodule

// File: rtl/rx_err_dp.sv
module rx_err_dp
  import rx_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] errStrb,
  input  cpuStrb_t             strb,
  input  logic [DATA_W-1:0]    cpuWdata,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] enables;
  logic [NUM_FLAGS-1:0] armed;

  always_ff @(posedge clk) begin
    if (rst) enables <= '0;
    else if (strb.ctrlWr) enables <= cpuWdata[NUM_FLAGS-1:0];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else if (errStrb[i]) begin
        flags[i] <= 1'b1;
        armed[i] <= 1'b0;
      end else if (armed[i] && strb.dataAcc) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else if (strb.statRd && flags[i]) begin
        armed[i] <= 1'b1;
      end
    end

    AST_STROBE_SETS: assert property (@(posedge clk) disable iff (rst)
      errStrb[i] |=> (flags[i] && !armed[i])); // R1

    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(armed[i] && strb.dataAcc)) |=> flags[i]); // R5

    AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
      armed[i] |-> flags[i]); // R4
  end

  always_comb irq = |(flags & enables);
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int STAT_ADDR = 0,
  parameter int DATA_ADDR = 1,
  parameter int CTRL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameErrStrobe,
  input  logic              parityErrStrobe,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              brkActive,
  input  logic              brkClrEn,
  output logic              frameErrFlag,
  output logic              parityErrFlag,
  output logic              errIrq
);
  cpuStrb_t             strb;
  logic [NUM_FLAGS-1:0] errStrb;
  logic [NUM_FLAGS-1:0] flags;

  always_comb begin
    errStrb              = '0;
    errStrb[FLAG_FRAME]  = frameErrStrobe;
    errStrb[FLAG_PARITY] = parityErrStrobe;
  end

  rx_err_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .brkActive(brkActive), .brkClrEn(brkClrEn), .strb(strb)
  );

  rx_err_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .errStrb(errStrb), .strb(strb),
    .cpuWdata(cpuWdata), .flags(flags), .irq(errIrq)
  );

  assign frameErrFlag  = flags[FLAG_FRAME];
  assign parityErrFlag = flags[FLAG_PARITY];

  AST_BRK_HOLD_FRAME: assert property (@(posedge clk) disable iff (rst)
    (brkActive && !brkClrEn && frameErrFlag) |=> frameErrFlag); // R8

  AST_BRK_HOLD_PARITY: assert property (@(posedge clk) disable iff (rst)
    (brkActive && !brkClrEn && parityErrFlag) |=> parityErrFlag); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    errIrq |-> (frameErrFlag || parityErrFlag)); // R3
endmodule

// File: tb/rx_err_status_bench.sv
module rx_err_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fs = 1'b0, ps = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = 8'h00;
  logic       brk = 1'b0, clrEn = 1'b0;
  logic       fFlag, pFlag, irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  rx_err_status u_rx_err_status (
    .clk(clk), .rst(rst), .frameErrStrobe(fs), .parityErrStrobe(ps),
    .cpuRd(rd), .cpuWr(wr), .cpuAddr(addr), .cpuWdata(wdata),
    .brkActive(brk), .brkClrEn(clrEn),
    .frameErrFlag(fFlag), .parityErrFlag(pFlag), .errIrq(irq)
  );

  // Expected item layout: {frame flag, parity flag, irq}
  task automatic step(input logic r, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input logic f, input logic p,
                      input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; fs = f; ps = p;
    @(posedge clk);
    #1;
    rd = 1'b0; wr = 1'b0; fs = 1'b0; ps = 1'b0; addr = 2'd3;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      tests++;
      if ({fFlag, pFlag, irq} !== it.exp) begin
        fails++;
        $display("FAIL %s: got %b expected %b", it.tag, {fFlag, pFlag, irq}, it.exp);
      end
    end
  end

  initial begin
    step(0, 0, 3, 0, 0, 0, 3'b000, "R11 reset state");
    rst = 1'b0;
    step(0, 0, 3, 0, 1, 0, 3'b100, "R1 frame strobe sets");
    step(0, 1, 2, 8'h01, 0, 0, 3'b101, "R3 frame enable bit0");
    step(0, 0, 3, 0, 0, 1, 3'b111, "R2 parity strobe sets");
    step(0, 1, 2, 8'h02, 0, 0, 3'b111, "R3 parity enable bit1");
    step(0, 1, 2, 8'h00, 0, 0, 3'b110, "R3 all masked");
    step(1, 0, 1, 0, 0, 0, 3'b110, "R5 data read without status read");
    step(1, 0, 0, 0, 0, 0, 3'b110, "R4 status read");
    step(0, 1, 1, 0, 0, 0, 3'b000, "R4 data write clears both");
    step(0, 0, 3, 0, 1, 0, 3'b100, "R6 frame set");
    step(1, 0, 0, 0, 0, 0, 3'b100, "R6 status read");
    step(0, 0, 3, 0, 1, 0, 3'b100, "R6 new strobe between steps");
    step(1, 0, 1, 0, 0, 0, 3'b100, "R6 clear cancelled");
    step(1, 0, 0, 0, 0, 0, 3'b100, "R7 status read");
    step(1, 0, 1, 0, 1, 0, 3'b100, "R7 strobe with data access");
    step(1, 0, 1, 0, 0, 0, 3'b100, "R7 pending used up");
    step(1, 0, 0, 0, 0, 0, 3'b100, "R4 status read again");
    step(1, 0, 1, 0, 0, 0, 3'b000, "R4 clear");
    step(0, 0, 3, 0, 0, 1, 3'b010, "R2 parity set");
    brk = 1'b1; clrEn = 1'b0;
    step(1, 0, 0, 0, 0, 0, 3'b010, "R8 status read in break");
    step(1, 0, 1, 0, 0, 0, 3'b010, "R8 data read in break");
    brk = 1'b0;
    step(1, 0, 1, 0, 0, 0, 3'b010, "R8 break read did not arm");
    step(1, 0, 0, 0, 0, 0, 3'b010, "R9 status read before break");
    brk = 1'b1;
    step(1, 0, 1, 0, 0, 0, 3'b010, "R9 frozen in break");
    brk = 1'b0;
    step(1, 0, 1, 0, 0, 0, 3'b000, "R9 clear completes after break");
    step(0, 0, 3, 0, 1, 0, 3'b100, "R10 frame set");
    brk = 1'b1; clrEn = 1'b1;
    step(1, 0, 0, 0, 0, 0, 3'b100, "R10 status read in break");
    step(0, 1, 1, 0, 0, 0, 3'b000, "R10 clear in break");
    brk = 1'b0; clrEn = 1'b0;
    step(0, 0, 3, 0, 0, 0, 3'b000, "R10 stays clear after break");
    step(0, 0, 3, 0, 1, 0, 3'b100, "R11 prep frame");
    step(0, 1, 2, 8'h01, 0, 0, 3'b101, "R11 prep enable");
    rst = 1'b1;
    step(0, 0, 3, 0, 0, 0, 3'b000, "R11 reset clears");
    rst = 1'b0;
    step(0, 0, 3, 0, 1, 0, 3'b100, "R11 enables were reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule